// File: doc/BRIEF.md
# I2C Telemetry Slave with Coherent Snapshots

This block is an I2C slave through which a host reads a small bank of monitoring registers. Live measurement bytes and status flags come in on internal ports. On a timed schedule the block copies all of them into a readable bank, and every register in the bank is loaded in the same clock cycle. The host never reads the live inputs directly. It only reads the most recent snapshot.

To read, the host first writes one byte that sets an internal data pointer. It then starts a read transfer, either after a repeated START or after STOP and a new START. The slave returns the register the pointer selects. The pointer advances after each byte, so one burst can sweep the bank. The first snapshot is taken after a startup delay, and later ones follow at a fixed period. Both intervals are counted in ticks of a parameterized prescaler on the system clock. If a snapshot falls due during a read burst, it waits until the burst ends. A burst therefore never mixes two generations of data.

Top module: `i2c_telem_slave`

## Requirements
- R1: After reset, `sda_oe` is low, and every register reads 0x00 until the first snapshot has been taken.
- R2: The first snapshot loads the bank on clock edge PRESCALE*STARTUP_TICKS after reset is released. Later snapshots come every PRESCALE*PERIOD_TICKS edges, unless one is deferred by R9.
- R3: A snapshot loads every register of the bank in one clock cycle, and the bank changes at no other time.
- R4: A falling SDA while SCL is high is taken as START, and a rising SDA while SCL is high is taken as STOP. After either, the slave stops pulling SDA low.
- R5: The address byte is received MSB first. Its upper seven bits are compared with {ADDR_HI, addr_sel}, and its last bit is the direction (1 means the host reads, 0 means the host writes). The slave pulls SDA low in the ACK slot only when the address matches. On a mismatch it stays released and ignores the rest of the transfer.
- R6: In a write transfer, each data byte is acknowledged and loaded into the data pointer.
- R7: In a read transfer, bytes are sent MSB first from the register the pointer selects. Pointers 0 to NUM_MEAS-1 select measurement byte k, which is `meas_live[8k+7:8k]` at snapshot time. Pointer NUM_MEAS selects the status byte, with the flags in bits NUM_FLAGS-1:0 and zeros above them. Any higher pointer reads 0x00.
- R8: The pointer advances by one after each byte sent. A host ACK (SDA low) makes the slave send the next byte. A host NACK ends the burst, and SDA stays released until STOP.
- R9: A snapshot that falls due while a read transfer is open (from the address match until STOP or START) is taken only after that transfer closes.
- R10: The SDA output enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | I2C clock line as seen on the bus |
| sda_in | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When high, the slave pulls SDA low (open drain) |
| addr_sel | input | 1 | Strap pin that supplies the lowest address bit |
| meas_live | input | NUM_MEAS*8 | Live measurement bytes, with byte k at bits 8k+7:8k |
| flags_live | input | NUM_FLAGS | Live status flags |

## Verification
A pointer write followed by a read is run in three timing cases. The first is before the startup delay, to separate the reset state from the first snapshot. The second is after the startup delay. The third is after the live inputs have changed, to show the periodic refresh. A burst is stretched across a change of the live inputs to separate a deferred snapshot from one that lands in the middle of the burst. A read right after STOP shows that the deferred snapshot is then taken. Wrong addresses are tried with both strap settings, and out-of-range pointers are read. Random pointers, burst lengths and choices between repeated START and STOP-then-START test the pointer stepping and the register map against a model of the bank.

// File: rtl/i2c_telem_pkg.sv
package i2c_telem_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } link_st_e;

  // saturating pointer step
  function automatic logic [BYTE_W-1:0] ptr_step(input logic [BYTE_W-1:0] p);
    return (p == {BYTE_W{1'b1}}) ? p : p + 1'b1;
  endfunction

  // upper seven bits of the received address byte against our own address
  function automatic logic addr_hit(input logic [6:0] own, input logic [BYTE_W-1:0] rx);
    return rx[7:1] == own;
  endfunction

  // bit of an outgoing byte that goes on the wire after cnt bits already sent
  function automatic logic tx_bit(input logic [BYTE_W-1:0] b, input logic [3:0] cnt);
    return b[3'd7 - cnt[2:0]];
  endfunction
endpackage

// File: rtl/i2c_telem_sync.sv
module i2c_telem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic       scl_s;
  logic       scl_d;
  logic       sda_d;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  assign scl_s = synced[0];
  assign sda_s = synced[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_telem_snap.sv
module i2c_telem_snap #(
  parameter int PRESCALE      = 50000,
  parameter int STARTUP_TICKS = 300,
  parameter int PERIOD_TICKS  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic fire
);
  localparam int TMAX = (STARTUP_TICKS > PERIOD_TICKS) ? STARTUP_TICKS : PERIOD_TICKS;
  localparam int PC_W = $clog2(PRESCALE + 1);
  localparam int TC_W = $clog2(TMAX + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PRESCALE - 1);
  localparam logic [TC_W-1:0] TC_FIRST = TC_W'(STARTUP_TICKS - 1);
  localparam logic [TC_W-1:0] TC_PER   = TC_W'(PERIOD_TICKS - 1);

  logic [PC_W-1:0] pc;
  logic [TC_W-1:0] tc;
  logic            first_done;
  logic            pending;
  logic            tick;
  logic            due;
  logic [TC_W-1:0] tgt;

  assign tick = (pc == PC_LAST);
  assign tgt  = first_done ? TC_PER : TC_FIRST;
  assign due  = tick && (tc == tgt);
  assign fire = (pending | due) & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= '0;
      tc         <= '0;
      first_done <= 1'b0;
      pending    <= 1'b0;
    end else begin
      pc      <= tick ? '0 : pc + 1'b1;
      pending <= (pending | due) & hold;
      if (tick) begin
        if (due) begin
          tc         <= '0;
          first_done <= 1'b1;
        end else begin
          tc <= tc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_telem_bank.sv
module i2c_telem_bank
  import i2c_telem_pkg::*;
#(
  parameter int NUM_MEAS  = 5,
  parameter int NUM_FLAGS = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load,
  input  logic [NUM_MEAS*BYTE_W-1:0]         meas_live,
  input  logic [NUM_FLAGS-1:0]               flags_live,
  input  logic [BYTE_W-1:0]                  ptr,
  output logic [BYTE_W-1:0]                  rd_byte,
  output logic [(NUM_MEAS+1)*BYTE_W-1:0]     bank_flat
);
  localparam int NUM_REGS = NUM_MEAS + 1;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] live_b;
    logic [BYTE_W-1:0] held;
    if (i < NUM_MEAS) begin : g_meas
      assign live_b = meas_live[i*BYTE_W +: BYTE_W];
    end else begin : g_stat
      assign live_b = BYTE_W'(flags_live);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (load) held <= live_b;
    end
    assign bank_flat[i*BYTE_W +: BYTE_W] = held;
  end

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (ptr == BYTE_W'(k)) rd_byte = bank_flat[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/i2c_telem_fsm.sv
module i2c_telem_fsm
  import i2c_telem_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_sel,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr,
  output logic              rd_busy
);
  link_st_e          st;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              host_ack;
  logic [6:0]        own_addr;

  assign own_addr = {ADDR_HI, addr_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      rd_busy  <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      sda_oe  <= 1'b0;
      rd_busy <= 1'b0;
    end else if (start_det) begin
      st      <= ST_ADDR;
      cnt     <= '0;
      sda_oe  <= 1'b0;
      rd_busy <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (addr_hit(own_addr, sh)) begin
              sda_oe  <= 1'b1;
              rw      <= sh[0];
              rd_busy <= sh[0];
              st      <= ST_ADDR_ACK;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              st     <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise && cnt < 4'd8) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            ptr    <= sh;
            sda_oe <= 1'b1;
            st     <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise && cnt < 4'd8) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= ptr_step(ptr);
              st     <= ST_RD_ACK;
            end else if (cnt != 4'd0) begin
              sda_oe <= ~tx_bit(tx, cnt);
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[BYTE_W-1];
              cnt    <= '0;
              st     <= ST_RD;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_telem_slave.sv
module i2c_telem_slave
  import i2c_telem_pkg::*;
#(
  parameter int         NUM_MEAS      = 5,
  parameter int         NUM_FLAGS     = 6,
  parameter logic [5:0] ADDR_HI       = 6'h2C,
  parameter int         PRESCALE      = 50000,
  parameter int         STARTUP_TICKS = 300,
  parameter int         PERIOD_TICKS  = 100,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_in,
  input  logic                       sda_in,
  output logic                       sda_oe,
  input  logic                       addr_sel,
  input  logic [NUM_MEAS*BYTE_W-1:0] meas_live,
  input  logic [NUM_FLAGS-1:0]       flags_live
);
  localparam int BANK_W = (NUM_MEAS + 1) * BYTE_W;

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              rd_busy;
  logic              snap_fire;
  logic [BYTE_W-1:0] ptr;
  logic [BYTE_W-1:0] rd_byte;
  logic [BANK_W-1:0] bank_flat;

  i2c_telem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_telem_snap #(
    .PRESCALE      (PRESCALE),
    .STARTUP_TICKS (STARTUP_TICKS),
    .PERIOD_TICKS  (PERIOD_TICKS)
  ) u_snap (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (rd_busy),
    .fire  (snap_fire)
  );

  i2c_telem_bank #(.NUM_MEAS(NUM_MEAS), .NUM_FLAGS(NUM_FLAGS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (snap_fire),
    .meas_live  (meas_live),
    .flags_live (flags_live),
    .ptr        (ptr),
    .rd_byte    (rd_byte),
    .bank_flat  (bank_flat)
  );

  i2c_telem_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .addr_sel  (addr_sel),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .ptr       (ptr),
    .rd_busy   (rd_busy)
  );
endmodule

// File: rtl/i2c_telem_chk.sv
module i2c_telem_chk #(
  parameter int PRESCALE      = 50000,
  parameter int STARTUP_TICKS = 300,
  parameter int BANK_W        = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_in,
  input logic              sda_oe,
  input logic              start_det,
  input logic              stop_det,
  input logic              snap_fire,
  input logic              rd_busy,
  input logic [BANK_W-1:0] bank_flat
);
  localparam longint FIRST_EDGE = longint'(PRESCALE) * longint'(STARTUP_TICKS);
  localparam logic [31:0] FIRST_CYC = 32'(FIRST_EDGE - 1);

  logic [31:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc <= '0;
    else if (cyc != 32'hFFFFFFFF) cyc <= cyc + 1'b1;
  end

  // R3
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_flat != $past(bank_flat)) |-> $past(snap_fire));

  // R9
  snap_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |-> !rd_busy);

  // R2
  snap_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |-> (cyc >= FIRST_CYC));

  // R4
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);
endmodule

bind i2c_telem_slave i2c_telem_chk #(
  .PRESCALE      (PRESCALE),
  .STARTUP_TICKS (STARTUP_TICKS),
  .BANK_W        ((NUM_MEAS + 1) * 8)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .snap_fire (snap_fire),
  .rd_busy   (rd_busy),
  .bank_flat (bank_flat)
);

// File: tb/i2c_telem_slave_bench.sv
`timescale 1ns/1ps
module i2c_telem_slave_bench;
  localparam int NM  = 5;
  localparam int NF  = 6;
  localparam int P   = 4;
  localparam int TS  = 300;
  localparam int TP  = 100;
  localparam int Q   = 5;
  localparam logic [6:0] A0 = 7'h58;
  localparam logic [6:0] A1 = 7'h59;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic addr_sel = 1'b0;
  logic [NM*8-1:0] meas = '0;
  logic [NF-1:0] flags = '0;
  logic sda_oe;
  logic scl_in;
  logic sda_in;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  int cyc = 0;
  logic oe_prev = 1'b0;

  assign scl_in = scl_h;
  assign sda_in = sda_h & ~sda_oe;

  always #2 clk = ~clk;

  i2c_telem_slave #(
    .NUM_MEAS (NM), .NUM_FLAGS (NF), .ADDR_HI (6'h2C),
    .PRESCALE (P), .STARTUP_TICKS (TS), .PERIOD_TICKS (TP), .SYNC_STAGES (2)
  ) u_i2c_telem_slave (
    .clk (clk), .rst_n (rst_n), .scl_in (scl_in), .sda_in (sda_in),
    .sda_oe (sda_oe), .addr_sel (addr_sel), .meas_live (meas), .flags_live (flags)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // R10 monitor: the enable must not move while the bus clock is high
  always @(posedge clk) begin
    #1;
    if (rst_n && (sda_oe !== oe_prev) && scl_in) oe_viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] exp_reg(input int p, input logic [NM*8-1:0] m, input logic [NF-1:0] f);
    if (p < NM) return m[p*8 +: 8];
    else if (p == NM) return {{(8-NF){1'b0}}, f};
    else return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; wt(Q);
    sda_h = 1'b0; wt(Q);
    scl_h = 1'b0; wt(Q);
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; wt(Q);
    scl_h = 1'b1; wt(Q);
    sda_h = 1'b0; wt(Q);
    scl_h = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wt(Q);
    scl_h = 1'b1; wt(Q);
    sda_h = 1'b1; wt(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_h = b; wt(Q);
    scl_h = 1'b1; wt(2*Q);
    scl_h = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; wt(Q);
    scl_h = 1'b1; wt(Q);
    b = sda_in; wt(Q);
    scl_h = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(last);
  endtask

  // pointer write, then a read burst checked against a model of the bank
  task automatic read_burst(input int p, input int len, input logic use_rs,
                            input logic [NM*8-1:0] m, input logic [NF-1:0] f, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    put_byte({A0, 1'b0}, ack); chk("R5 write address ACK", {7'b0, ack}, 8'h01);
    put_byte(8'(p), ack);      chk("R6 pointer byte ACK", {7'b0, ack}, 8'h01);
    if (use_rs) bus_rstart();
    else begin bus_stop(); bus_start(); end
    put_byte({A0, 1'b1}, ack); chk("R5 read address ACK", {7'b0, ack}, 8'h01);
    for (int i = 0; i < len; i++) begin
      get_byte(i == len - 1, d);
      chk(req, d, exp_reg(p + i, m, f));
    end
    chk("R8 SDA released after NACK", {7'b0, sda_oe}, 8'h00);
    bus_stop();
    chk("R4 SDA released after STOP", {7'b0, sda_oe}, 8'h00);
  endtask

  task automatic finish_run();
    checks++;
    if (oe_viol != 0) begin
      errors++;
      $display("FAIL R10: actual %0d enable changes with SCL high, expected 0", oe_viol);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [NM*8-1:0] ma;
    logic [NF-1:0] fa;
    void'($urandom(32'h5EED1234));
    meas  = 40'h11_22_33_44_A5;
    flags = 6'h2A;
    wt(5);
    rst_n = 1'b1;
    wt(1);
    chk("R1 sda_oe low after reset", {7'b0, sda_oe}, 8'h00);

    // R1: a read that ends before the first snapshot sees zeros
    read_burst(0, 2, 1'b1, '0, '0, "R1 register zero before first snapshot");

    // R2: after the startup delay the bank holds the live values
    while (cyc < 1300) wt(1);
    read_burst(0, 6, 1'b1, meas, flags, "R2 first snapshot content, R8 auto-increment");

    // R2: periodic refresh picks up new live values
    meas  = 40'h9C_87_76_65_54;
    flags = 6'h15;
    wt(TP * P + 50);
    read_burst(3, 3, 1'b0, meas, flags, "R2 periodic refresh, R7 status byte");

    // R7: pointers beyond the bank
    read_burst(6, 2, 1'b1, meas, flags, "R7 out-of-range pointer");
    read_burst(4, 4, 1'b1, meas, flags, "R7 run past status into empty space");

    // R5: wrong addresses and the strap pin
    bus_start();
    put_byte({A1, 1'b0}, ack); chk("R5 no ACK for 0x59 with strap low", {7'b0, ack}, 8'h00);
    bus_stop();
    addr_sel = 1'b1;
    wt(4);
    bus_start();
    put_byte({A0, 1'b1}, ack); chk("R5 no ACK for 0x58 with strap high", {7'b0, ack}, 8'h00);
    bus_stop();
    bus_start();
    put_byte({A1, 1'b0}, ack); chk("R5 ACK for 0x59 with strap high", {7'b0, ack}, 8'h01);
    put_byte(8'd1, ack);       chk("R6 pointer ACK", {7'b0, ack}, 8'h01);
    bus_rstart();
    put_byte({A1, 1'b1}, ack); chk("R5 read ACK for 0x59", {7'b0, ack}, 8'h01);
    get_byte(1'b1, d);         chk("R7 byte at pointer 1", d, exp_reg(1, meas, flags));
    bus_stop();
    addr_sel = 1'b0;
    wt(4);

    // R3 / R9: live values change mid-burst, the burst stays on one snapshot
    ma = 40'hDE_AD_BE_EF_01;
    fa = 6'h3F;
    meas = ma; flags = fa;
    wt(TP * P + 50);
    bus_start();
    put_byte({A0, 1'b0}, ack); chk("R5 ACK", {7'b0, ack}, 8'h01);
    put_byte(8'd0, ack);       chk("R6 ACK", {7'b0, ack}, 8'h01);
    bus_rstart();
    put_byte({A0, 1'b1}, ack); chk("R5 ACK", {7'b0, ack}, 8'h01);
    for (int i = 0; i < 2; i++) begin
      get_byte(1'b0, d); chk("R3 coherent burst, early byte", d, exp_reg(i, ma, fa));
    end
    meas  = 40'h12_34_56_78_9A;
    flags = 6'h01;
    wt(TP * P * 2);
    for (int i = 2; i < 6; i++) begin
      get_byte(i == 5, d); chk("R9 snapshot deferred during burst", d, exp_reg(i, ma, fa));
    end
    bus_stop();
    read_burst(0, 6, 1'b1, meas, flags, "R9 deferred snapshot taken after STOP");

    // random pointers, lengths and restart styles
    for (int it = 0; it < 16; it++) begin
      int p;
      int len;
      logic rs;
      meas  = {$urandom, 8'($urandom)};
      flags = NF'($urandom);
      p   = int'($urandom_range(0, 7));
      len = int'($urandom_range(1, 4));
      rs  = 1'($urandom);
      wt(TP * P + 50);
      read_burst(p, len, rs, meas, flags, "R3 R7 random burst");
    end

    finish_run();
  end
endmodule